// File: doc/BRIEF.md
# Audio Clock Supervisor with Speed Detection and Start-up Mute

This block runs on the audio master clock. It measures how many master-clock cycles pass between rising edges of the frame (left/right) clock, and from that ratio it works out whether the converter runs at normal, double or quad sampling speed. It also watches the frame and bit clocks for activity. It then steps the rest of the converter through three phases: halted with the data path in reset, muted with the data path running but the output forced to zero, and running.

The frame and bit clock inputs are levels that have already been brought into the master-clock domain. A power-on reset, a missing clock or a ratio that is not recognised puts the block in the halted phase. Leaving that phase takes two consecutive frame periods of the same speed class. The mute phase then lasts a fixed number of frame-clock rising edges, chosen by the speed class. One set of lengths applies to the first start after power-on and a second set applies to every later restart.

Top module: `crd_clock_supervisor`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `dp_rst`=1, `force_zero`=1 and `ready`=0.
- R2: A frame period of 512, 768 or 1152 master cycles (each ±TOL) is normal speed, reported as `speed_mode`=2'b00.
- R3: A frame period of 256 or 384 master cycles (±TOL) is double speed, reported as `speed_mode`=2'b01.
- R4: A frame period of 128 or 192 master cycles (±TOL) is quad speed, reported as `speed_mode`=2'b10.
- R5: A period that lies more than TOL cycles away from every recognised ratio keeps the block halted (`dp_rst`=1, `ready`=0). An example is 517 with TOL=2.
- R6: The block leaves the halted phase only after two consecutive measured periods fall in the same speed class. The measurement must start from a rising edge seen while both clocks are active.
- R7: On the first start after power-on, the mute phase (`dp_rst`=0, `force_zero`=1) lasts MUTE_NORM, MUTE_DBL or MUTE_QUAD frame-clock rising edges for normal, double or quad speed. `ready` rises in the cycle after the last of those edges.
- R8: On every later start, the mute phase lasts RESUME_NORM, RESUME_DBL or RESUME_QUAD rising edges instead.
- R9: If the frame clock shows no edge for LR_TIMEOUT master cycles, the block halts. It does not halt before that.
- R10: If the bit clock shows no edge for BCK_TIMEOUT master cycles, the block halts.
- R11: `ready`=1 implies `force_zero`=0 and `dp_rst`=0. `dp_rst`=1 implies `force_zero`=1.
- R12: A change of speed class while running halts the block. It then locks to the new class and holds `speed_mode` constant while `ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_mst | input | 1 | Master clock; all logic runs on its rising edge |
| rst_n | input | 1 | Active-low power-on reset |
| lrck_lvl | input | 1 | Synchronised frame clock level |
| bck_lvl | input | 1 | Synchronised bit clock level |
| speed_mode | output | 2 | Speed class of the last lock: 00 normal, 01 double, 10 quad |
| dp_rst | output | 1 | Reset for the downstream data path |
| force_zero | output | 1 | Forces the converter output to zero |
| ready | output | 1 | High while data flows normally |

## Verification
The bench drives clean frame and bit clocks at chosen ratios. A scoreboard counts the frame-clock rising edges that occur inside each mute phase and compares the count with the length expected for that speed class and for first start versus restart. A design that mixes up the two sets of lengths, or counts one edge too many or too few, shows up there. A design that locks after a single period is caught by the halt check made before the third frame edge. Periods just inside and just outside the tolerance window are driven to catch a wrong window width. The bench also drives a class change from normal to quad in the middle of a run. A design that kept its old lock would never go back through a mute phase and would report the wrong mode. Each clock is stopped on its own. The frame-clock stop is checked on both sides of the timeout, so a design that halts too early or never halts fails.

// File: rtl/crd_pkg.sv
package crd_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10,
        SPD_NONE   = 2'b11
    } speed_e;

    typedef enum logic [1:0] {
        SQ_HALT = 2'b00,
        SQ_MUTE = 2'b01,
        SQ_RUN  = 2'b10
    } seq_e;

    localparam int unsigned NUM_RATIOS = 7;

    // master cycles per frame for each recognised ratio, and the speed class of each
    localparam int unsigned RATIO_TAB [NUM_RATIOS] = '{128, 192, 256, 384, 512, 768, 1152};
    localparam speed_e      CLASS_TAB [NUM_RATIOS] = '{SPD_QUAD, SPD_QUAD, SPD_DOUBLE, SPD_DOUBLE,
                                                       SPD_NORMAL, SPD_NORMAL, SPD_NORMAL};

endpackage

// File: rtl/crd_activity_watch.sv
module crd_activity_watch #(
    parameter int unsigned TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic alive_o
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] idle;
    } watch_t;

    watch_t watch_d, watch_q;
    logic   toggled;

    always_comb begin
        watch_d     = watch_q;
        watch_d.lvl = lvl;
        toggled     = lvl ^ watch_q.lvl;
        if (toggled) begin
            watch_d.idle = '0;
        end else if (watch_q.idle != LIMIT) begin
            watch_d.idle = watch_q.idle + 1'b1;
        end
        alive_o = (watch_q.idle != LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            watch_q.lvl  <= 1'b0;
            watch_q.idle <= LIMIT;
        end else begin
            watch_q <= watch_d;
        end
    end

endmodule

// File: rtl/crd_period_meter.sv
module crd_period_meter
    import crd_pkg::*;
#(
    parameter int unsigned TOL       = 2,
    parameter int unsigned MAX_RATIO = 1152
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clear,
    input  logic   lr_lvl,
    output logic   rise_o,
    output speed_e mode_o,
    output logic   locked_o
);
    localparam int unsigned CW = $clog2(MAX_RATIO + TOL + 2);

    typedef struct packed {
        logic          lr;
        logic          have_ref;
        logic [CW-1:0] cnt;
        speed_e        prev;
        speed_e        mode;
        logic          locked;
    } meter_t;

    meter_t meter_d, meter_q;
    speed_e cls;

    function automatic speed_e classify(input logic [CW-1:0] per);
        int     pv;
        speed_e res;
        pv  = int'({{(32-CW){1'b0}}, per});
        res = SPD_NONE;
        for (int i = 0; i < int'(NUM_RATIOS); i++) begin
            if ((pv + int'(TOL) >= int'(RATIO_TAB[i])) && (pv <= int'(RATIO_TAB[i]) + int'(TOL))) begin
                res = CLASS_TAB[i];
            end
        end
        return res;
    endfunction

    always_comb begin
        meter_d    = meter_q;
        meter_d.lr = lr_lvl;
        rise_o     = lr_lvl & ~meter_q.lr;
        cls        = classify(meter_q.cnt);

        if (meter_q.cnt != '1) begin
            meter_d.cnt = meter_q.cnt + 1'b1;
        end
        if (rise_o) begin
            meter_d.cnt = CW'(1);
        end

        if (clear) begin
            meter_d.have_ref = 1'b0;
            meter_d.prev     = SPD_NONE;
            meter_d.locked   = 1'b0;
        end else if (rise_o) begin
            if (!meter_q.have_ref) begin
                meter_d.have_ref = 1'b1;
            end else if (cls == SPD_NONE) begin
                meter_d.prev   = SPD_NONE;
                meter_d.locked = 1'b0;
            end else if (cls == meter_q.prev) begin
                meter_d.locked = 1'b1;
                meter_d.mode   = cls;
            end else begin
                meter_d.prev   = cls;
                meter_d.locked = 1'b0;
            end
        end

        mode_o   = meter_q.mode;
        locked_o = meter_q.locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meter_q.lr       <= 1'b0;
            meter_q.have_ref <= 1'b0;
            meter_q.cnt      <= '0;
            meter_q.prev     <= SPD_NONE;
            meter_q.mode     <= SPD_NORMAL;
            meter_q.locked   <= 1'b0;
        end else begin
            meter_q <= meter_d;
        end
    end

endmodule

// File: rtl/crd_sequencer.sv
module crd_sequencer
    import crd_pkg::*;
#(
    parameter int unsigned MUTE_NORM   = 176,
    parameter int unsigned MUTE_DBL    = 352,
    parameter int unsigned MUTE_QUAD   = 704,
    parameter int unsigned RESUME_NORM = 180,
    parameter int unsigned RESUME_DBL  = 360,
    parameter int unsigned RESUME_QUAD = 720
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clocks_ok,
    input  logic   locked,
    input  speed_e mode,
    input  logic   rise,
    output logic   dp_rst,
    output logic   force_zero,
    output logic   ready
);
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    localparam int unsigned LONGEST = max2(max2(max2(MUTE_NORM, MUTE_DBL), max2(MUTE_QUAD, RESUME_NORM)),
                                           max2(RESUME_DBL, RESUME_QUAD));
    localparam int unsigned MW = $clog2(LONGEST + 1);

    typedef struct packed {
        seq_e          st;
        logic          booted;
        logic [MW-1:0] cnt;
        logic [MW-1:0] tgt;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic [MW-1:0] tgt_sel;
    logic [MW:0]   cnt_next;

    always_comb begin
        unique case (mode)
            SPD_DOUBLE: tgt_sel = seq_q.booted ? MW'(RESUME_DBL)  : MW'(MUTE_DBL);
            SPD_QUAD:   tgt_sel = seq_q.booted ? MW'(RESUME_QUAD) : MW'(MUTE_QUAD);
            default:    tgt_sel = seq_q.booted ? MW'(RESUME_NORM) : MW'(MUTE_NORM);
        endcase
    end

    always_comb begin
        seq_d    = seq_q;
        cnt_next = {1'b0, seq_q.cnt} + 1'b1;

        unique case (seq_q.st)
            SQ_HALT: begin
                if (clocks_ok && locked) begin
                    seq_d.st  = SQ_MUTE;
                    seq_d.cnt = '0;
                    seq_d.tgt = tgt_sel;
                end
            end
            SQ_MUTE: begin
                if (rise) begin
                    if (cnt_next >= {1'b0, seq_q.tgt}) begin
                        seq_d.st     = SQ_RUN;
                        seq_d.booted = 1'b1;
                    end else begin
                        seq_d.cnt = cnt_next[MW-1:0];
                    end
                end
            end
            default: begin
                seq_d.st = SQ_RUN;
            end
        endcase

        if (!clocks_ok || !locked) begin
            seq_d.st = SQ_HALT;
        end

        dp_rst     = (seq_q.st == SQ_HALT);
        force_zero = (seq_q.st != SQ_RUN);
        ready      = (seq_q.st == SQ_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st     <= SQ_HALT;
            seq_q.booted <= 1'b0;
            seq_q.cnt    <= '0;
            seq_q.tgt    <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/crd_clock_supervisor.sv
module crd_clock_supervisor
    import crd_pkg::*;
#(
    parameter int unsigned TOL         = 2,
    parameter int unsigned MAX_RATIO   = 1152,
    parameter int unsigned LR_TIMEOUT  = 4096,
    parameter int unsigned BCK_TIMEOUT = 64,
    parameter int unsigned MUTE_NORM   = 176,
    parameter int unsigned MUTE_DBL    = 352,
    parameter int unsigned MUTE_QUAD   = 704,
    parameter int unsigned RESUME_NORM = 180,
    parameter int unsigned RESUME_DBL  = 360,
    parameter int unsigned RESUME_QUAD = 720
) (
    input  logic       clk_mst,
    input  logic       rst_n,
    input  logic       lrck_lvl,
    input  logic       bck_lvl,
    output logic [1:0] speed_mode,
    output logic       dp_rst,
    output logic       force_zero,
    output logic       ready
);
    logic   lr_alive;
    logic   bck_alive;
    logic   clocks_ok;
    logic   lr_rise;
    logic   locked;
    speed_e mode;

    crd_activity_watch #(.TIMEOUT(LR_TIMEOUT)) u_lr_watch (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .lvl     (lrck_lvl),
        .alive_o (lr_alive)
    );

    crd_activity_watch #(.TIMEOUT(BCK_TIMEOUT)) u_bck_watch (
        .clk     (clk_mst),
        .rst_n   (rst_n),
        .lvl     (bck_lvl),
        .alive_o (bck_alive)
    );

    assign clocks_ok = lr_alive & bck_alive;

    crd_period_meter #(.TOL(TOL), .MAX_RATIO(MAX_RATIO)) u_meter (
        .clk      (clk_mst),
        .rst_n    (rst_n),
        .clear    (!clocks_ok),
        .lr_lvl   (lrck_lvl),
        .rise_o   (lr_rise),
        .mode_o   (mode),
        .locked_o (locked)
    );

    crd_sequencer #(
        .MUTE_NORM   (MUTE_NORM),
        .MUTE_DBL    (MUTE_DBL),
        .MUTE_QUAD   (MUTE_QUAD),
        .RESUME_NORM (RESUME_NORM),
        .RESUME_DBL  (RESUME_DBL),
        .RESUME_QUAD (RESUME_QUAD)
    ) u_seq (
        .clk        (clk_mst),
        .rst_n      (rst_n),
        .clocks_ok  (clocks_ok),
        .locked     (locked),
        .mode       (mode),
        .rise       (lr_rise),
        .dp_rst     (dp_rst),
        .force_zero (force_zero),
        .ready      (ready)
    );

    assign speed_mode = mode;

endmodule

// File: rtl/crd_clock_supervisor_chk.sv
module crd_clock_supervisor_chk #(
    parameter int unsigned LR_TIMEOUT  = 4096,
    parameter int unsigned BCK_TIMEOUT = 64
) (
    input logic       clk_mst,
    input logic       rst_n,
    input logic       lrck_lvl,
    input logic       bck_lvl,
    input logic [1:0] speed_mode,
    input logic       dp_rst,
    input logic       force_zero,
    input logic       ready
);
    localparam int unsigned LR_LIM  = LR_TIMEOUT + 2;
    localparam int unsigned BCK_LIM = BCK_TIMEOUT + 2;
    localparam int unsigned LW      = $clog2(LR_LIM + 1);
    localparam int unsigned BW      = $clog2(BCK_LIM + 1);

    logic          lr_prev, bck_prev;
    logic [LW-1:0] lr_idle;
    logic [BW-1:0] bck_idle;

    always_ff @(posedge clk_mst or negedge rst_n) begin
        if (!rst_n) begin
            lr_prev  <= 1'b0;
            bck_prev <= 1'b0;
            lr_idle  <= LW'(LR_LIM);
            bck_idle <= BW'(BCK_LIM);
        end else begin
            lr_prev  <= lrck_lvl;
            bck_prev <= bck_lvl;
            if (lrck_lvl != lr_prev) lr_idle <= '0;
            else if (lr_idle != LW'(LR_LIM)) lr_idle <= lr_idle + 1'b1;
            if (bck_lvl != bck_prev) bck_idle <= '0;
            else if (bck_idle != BW'(BCK_LIM)) bck_idle <= bck_idle + 1'b1;
        end
    end

    p_ready_clean_r11: assert property (@(posedge clk_mst) disable iff (!rst_n)
        ready |-> (!force_zero && !dp_rst));

    p_reset_zero_r11: assert property (@(posedge clk_mst) disable iff (!rst_n)
        dp_rst |-> force_zero);

    p_lr_loss_r9: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (lr_idle == LW'(LR_LIM)) |-> dp_rst);

    p_bck_loss_r10: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (bck_idle == BW'(BCK_LIM)) |-> dp_rst);

    p_mute_first_r7: assert property (@(posedge clk_mst) disable iff (!rst_n)
        $rose(ready) |-> $past(force_zero && !dp_rst));

    p_mode_hold_r12: assert property (@(posedge clk_mst) disable iff (!rst_n)
        (ready && $past(ready)) |-> $stable(speed_mode));

    p_mode_code_r2: assert property (@(posedge clk_mst) disable iff (!rst_n)
        ready |-> (speed_mode != 2'b11));

endmodule

bind crd_clock_supervisor crd_clock_supervisor_chk #(
    .LR_TIMEOUT  (LR_TIMEOUT),
    .BCK_TIMEOUT (BCK_TIMEOUT)
) u_chk (
    .clk_mst    (clk_mst),
    .rst_n      (rst_n),
    .lrck_lvl   (lrck_lvl),
    .bck_lvl    (bck_lvl),
    .speed_mode (speed_mode),
    .dp_rst     (dp_rst),
    .force_zero (force_zero),
    .ready      (ready)
);

// File: tb/crd_clock_supervisor_tb.sv
module crd_clock_supervisor_tb;

    localparam int LR_TO  = 4096;
    localparam int BCK_TO = 64;
    localparam int M_N = 6,  M_D = 12, M_Q = 24;
    localparam int R_N = 7,  R_D = 14, R_Q = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lrck = 1'b0;
    logic       bck = 1'b0;
    logic [1:0] speed_mode;
    logic       dp_rst, force_zero, ready;

    always #2 clk = ~clk;

    crd_clock_supervisor #(
        .TOL(2), .MAX_RATIO(1152), .LR_TIMEOUT(LR_TO), .BCK_TIMEOUT(BCK_TO),
        .MUTE_NORM(M_N), .MUTE_DBL(M_D), .MUTE_QUAD(M_Q),
        .RESUME_NORM(R_N), .RESUME_DBL(R_D), .RESUME_QUAD(R_Q)
    ) u_dut (
        .clk_mst(clk), .rst_n(rst_n), .lrck_lvl(lrck), .bck_lvl(bck),
        .speed_mode(speed_mode), .dp_rst(dp_rst), .force_zero(force_zero), .ready(ready)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // clock generator: frame period = ratio master cycles, bit clock = 64 per frame
    int ratio   = 512;
    bit lr_run  = 0;
    bit bck_run = 0;
    bit restart = 0;
    int ph  = 0;
    int bph = 0;

    always @(negedge clk) begin
        if (restart) begin
            ph  = 0;
            bph = 0;
        end
        if (lr_run) begin
            lrck = (ph < ratio / 2);
            ph   = (ph >= ratio - 1) ? 0 : ph + 1;
        end
        if (bck_run) begin
            if (bph >= ratio / 128 - 1) begin
                bck = ~bck;
                bph = 0;
            end else begin
                bph = bph + 1;
            end
        end
    end

    // scoreboard
    typedef struct {
        logic [1:0] mode;
        int         len;
        string      tag;
    } exp_t;
    exp_t exp_q[$];

    task automatic push_exp(input logic [1:0] m, input int len, input string tag);
        exp_t e;
        e.mode = m;
        e.len  = len;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    initial begin : monitor
        bit prev_mute  = 0;
        bit prev_lr    = 0;
        bit prev_ready = 0;
        int mute_edges = 0;
        forever begin
            @(posedge clk);
            #1;
            if (prev_mute && lrck && !prev_lr) mute_edges++;
            if (dp_rst) mute_edges = 0;
            if (ready && !prev_ready && rst_n) begin
                check(!force_zero && !dp_rst, "R11 outputs when ready", {30'd0, force_zero, dp_rst}, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected ready", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(mute_edges == e.len, {e.tag, " mute length"}, mute_edges, e.len);
                    check(speed_mode == e.mode, {e.tag, " speed_mode"}, int'(speed_mode), int'(e.mode));
                end
            end
            prev_mute  = force_zero && !dp_rst;
            prev_lr    = lrck;
            prev_ready = ready;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    task automatic do_reset();
        lr_run  = 0;
        bck_run = 0;
        rst_n   = 1'b0;
        restart = 1;
        repeat (5) @(posedge clk);
        restart = 0;
        rst_n   = 1'b1;
    endtask

    task automatic start_clocks(input int r);
        ratio   = r;
        restart = 1;
        @(posedge clk);
        restart = 0;
        lr_run  = 1;
        bck_run = 1;
    endtask

    task automatic wait_ready(input int limit, input string req);
        int n = 0;
        while (!ready && n < limit) begin
            @(posedge clk);
            n++;
        end
        #1;
        check(ready == 1'b1, req, int'(ready), 1);
    endtask

    initial begin : main
        // R1: reset state
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check(dp_rst == 1'b1 && force_zero == 1'b1 && ready == 1'b0, "R1 during reset",
              {29'd0, dp_rst, force_zero, ready}, 6);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(dp_rst == 1'b1 && force_zero == 1'b1 && ready == 1'b0, "R1 after release",
              {29'd0, dp_rst, force_zero, ready}, 6);

        // R2 + R7: first start at 512, normal speed
        push_exp(2'b00, M_N, "R2 R7 boot 512");
        start_clocks(512);
        repeat (2 * 512 - 20) @(posedge clk);
        #1;
        check(dp_rst == 1'b1, "R6 no lock before two periods", int'(dp_rst), 1);
        wait_ready(20000, "R7 ready after boot at 512");

        // R3: first start at 384, double speed
        do_reset();
        push_exp(2'b01, M_D, "R3 R7 boot 384");
        start_clocks(384);
        wait_ready(20000, "R3 ready after boot at 384");

        // R4: first start at 192, quad speed
        do_reset();
        push_exp(2'b10, M_Q, "R4 R7 boot 192");
        start_clocks(192);
        wait_ready(20000, "R4 ready after boot at 192");

        // R5: 770 is inside the window around 768
        do_reset();
        push_exp(2'b00, M_N, "R5 R2 boot 770");
        start_clocks(770);
        wait_ready(20000, "R5 ready at 770");

        // R5: 517 and 300 are outside every window
        do_reset();
        start_clocks(517);
        repeat (8000) @(posedge clk);
        #1;
        check(dp_rst == 1'b1 && ready == 1'b0, "R5 halted at 517", {30'd0, dp_rst, ready}, 2);
        ratio = 300;
        repeat (4000) @(posedge clk);
        #1;
        check(dp_rst == 1'b1 && ready == 1'b0, "R5 halted at 300", {30'd0, dp_rst, ready}, 2);

        // still the first start: 1152 uses the power-on length
        push_exp(2'b00, M_N, "R2 R7 boot 1152");
        ratio = 1152;
        wait_ready(30000, "R2 ready at 1152");

        // R12: class change from normal to quad while running
        @(posedge lrck);
        repeat (50) @(posedge clk);
        push_exp(2'b10, R_Q, "R12 R8 change to 128");
        ratio = 128;
        repeat (300) @(posedge clk);
        #1;
        check(ready == 1'b0, "R12 halt on class change", int'(ready), 0);
        wait_ready(20000, "R12 ready after change");

        // R9: frame clock stops
        lr_run = 0;
        repeat (LR_TO - 100) @(posedge clk);
        #1;
        check(ready == 1'b1, "R9 still running before timeout", int'(ready), 1);
        repeat (110) @(posedge clk);
        #1;
        check(dp_rst == 1'b1 && ready == 1'b0, "R9 halted after timeout", {30'd0, dp_rst, ready}, 2);
        push_exp(2'b00, R_N, "R8 resume 512");
        start_clocks(512);
        wait_ready(20000, "R8 ready after frame clock returns");

        // R10: bit clock stops
        bck_run = 0;
        repeat (BCK_TO - 10) @(posedge clk);
        #1;
        check(ready == 1'b1, "R10 still running before timeout", int'(ready), 1);
        repeat (20) @(posedge clk);
        #1;
        check(dp_rst == 1'b1 && force_zero == 1'b1, "R10 halted after bit clock stop",
              {30'd0, dp_rst, force_zero}, 3);
        push_exp(2'b01, R_D, "R8 R3 resume 256");
        ratio   = 256;
        bck_run = 1;
        wait_ready(20000, "R8 ready after bit clock returns");

        repeat (10) @(posedge clk);
        check(exp_q.size() == 0, "R7 all expected starts seen", exp_q.size(), 0);
        finish_run();
    end

endmodule